// File: doc/BRIEF.md
# Pulse-Count Register Write Decoder

This block accepts register writes from a host over a single write-only line that idles high. Each number is sent as a train of low-going pulses: the count of rising edges, minus one, is the value. A phase closes when the line stays high for a minimum hold time. The first phase of a transaction gives a 5-bit register address. The second gives a 6-bit data word. When the data phase closes cleanly, the block emits a one-cycle write strobe carrying both values, so that a register file beside it can store the word.

The same line also powers the device on and off. A long high level raises the device-enable output, and a longer low level drops it. The surrounding chip uses a low enable as the reset of its registers. The line passes through a synchronizer. Every duration is measured in ticks of a prescaler that divides the system clock and restarts on each level change of the line, so all timing is set by parameters.

Top module: `pulse_count_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, `dev_en` and `wr_en` are 0 and `wr_addr` and `wr_data` are all zeros.
- R2: When the synchronized line has stayed high for ENABLE_TICKS ticks, `dev_en` rises, 3 + ENABLE_TICKS*CLK_DIV clock cycles after the line input first reads high.
- R3: When the line stays low for SHUTDOWN_TICKS ticks, `dev_en` falls 3 + SHUTDOWN_TICKS*CLK_DIV cycles after the falling input, and any half-done transaction is dropped, so the next pulse train is taken as an address.
- R4: An address phase of 1 to 32 rising edges, closed by a high level of HOLD_TICKS ticks, selects address value edges-1.
- R5: A data phase of 1 to 64 rising edges, closed by a HOLD_TICKS hold, produces `wr_en`=1 for exactly one cycle, with `wr_addr` set to the selected address and `wr_data` set to edges-1. The strobe comes 3 + HOLD_TICKS*CLK_DIV cycles after the last rising input.
- R6: An address phase of more than 32 edges produces no write. After its hold, the next pulse train is an address.
- R7: A data phase of more than 64 edges produces no write. After its hold, the next pulse train is an address.
- R8: If the line stays high after an address for ADDR_HOLD_MAX_TICKS ticks, the address is abandoned and the next pulse train is an address.
- R9: `wr_en` is never 1 while `dev_en` is 0. A complete transaction sent while disabled produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous single-wire host line, idle high |
| dev_en | output | 1 | Device enable; low means the device is off and its registers are held at their defaults |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | DATA_W | Data word of the write |

## Verification
Each timed result is due a fixed number of cycles after the input edge that starts its interval. That number is two synchronizer flops, one cycle for the prescaler restart, and then the tick count times CLK_DIV: 3 + HOLD_TICKS*CLK_DIV for a strobe, and 3 + ENABLE_TICKS*CLK_DIV or 3 + SHUTDOWN_TICKS*CLK_DIV for the enable. The bench drives inputs on falling edges and counts rising edges from the one that first samples the change. It samples one cycle before the due edge and again right after it, so an early or late result fails. Cases that expect no write are checked against a strobe counter over a window longer than the hold latency.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } pcw_state_t;
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic chg
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      prev <= 1'b0;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign level = sr[STAGES-1];
  assign rise  = sr[STAGES-1] & ~prev;
  assign chg   = sr[STAGES-1] ^ prev;
endmodule

// File: rtl/pcw_level_timer.sv
module pcw_level_timer #(
  parameter int CLK_DIV = 200,
  parameter int RUN_MAX = 10000,
  localparam int PW = $clog2(CLK_DIV + 1),
  localparam int RW = $clog2(RUN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic          tick,
  output logic [RW-1:0] run
);
  logic [PW-1:0] pcnt;

  assign tick = (pcnt == PW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
      run  <= '0;
    end else if (tick) begin
      pcnt <= '0;
      if (run != RW'(RUN_MAX)) run <= run + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcw_decoder.sv
module pcw_decoder
  import pcw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 6,
  localparam int CW = ((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 1,
  localparam int A_EDGES = 2 ** ADDR_W,
  localparam int D_EDGES = 2 ** DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rise,
  input  logic              hold_ev,
  input  logic              amax_ev,
  input  logic              stby_ev,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  pcw_state_t        state;
  logic [CW-1:0]     cnt;
  logic              ovf;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ovf     <= 1'b0;
      addr_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (clear) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ovf   <= 1'b0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rise) begin
            state <= ST_ADDR;
            cnt   <= CW'(1);
            ovf   <= 1'b0;
          end
        end
        ST_ADDR: begin
          if (rise) begin
            if (cnt == CW'(A_EDGES)) ovf <= 1'b1;
            else                     cnt <= cnt + 1'b1;
          end else if (hold_ev) begin
            if (ovf) begin
              state <= ST_IDLE;
            end else begin
              addr_q <= ADDR_W'(cnt - CW'(1));
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (rise) begin
            state <= ST_DATA;
            cnt   <= CW'(1);
            ovf   <= 1'b0;
          end else if (amax_ev) begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (rise) begin
            if (cnt == CW'(D_EDGES)) ovf <= 1'b1;
            else                     cnt <= cnt + 1'b1;
          end else if (hold_ev) begin
            state <= ST_IDLE;
            if (!ovf) begin
              wr_en   <= 1'b1;
              wr_addr <= addr_q;
              wr_data <= DATA_W'(cnt - CW'(1));
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (stby_ev && !hold_ev) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/pulse_count_writer.sv
module pulse_count_writer #(
  parameter int CLK_DIV             = 200,
  parameter int HOLD_TICKS          = 500,
  parameter int ADDR_HOLD_MAX_TICKS = 5000,
  parameter int ENABLE_TICKS        = 1000,
  parameter int SHUTDOWN_TICKS      = 10000,
  parameter int STANDBY_TICKS       = 10000,
  parameter int ADDR_W              = 5,
  parameter int DATA_W              = 6,
  parameter int SYNC_STAGES         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  output logic              dev_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int M1 = (HOLD_TICKS > ADDR_HOLD_MAX_TICKS) ? HOLD_TICKS : ADDR_HOLD_MAX_TICKS;
  localparam int M2 = (ENABLE_TICKS > SHUTDOWN_TICKS) ? ENABLE_TICKS : SHUTDOWN_TICKS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int RUN_MAX = (M3 > STANDBY_TICKS) ? M3 : STANDBY_TICKS;
  localparam int RW = $clog2(RUN_MAX + 1);

  // Event thresholds, in ticks, for high and low levels
  localparam int NEV = 5;
  localparam int EV_LIM [NEV] = '{HOLD_TICKS, ADDR_HOLD_MAX_TICKS, STANDBY_TICKS,
                                  ENABLE_TICKS, SHUTDOWN_TICKS};
  localparam logic EV_LVL [NEV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic          line_s;
  logic          rise;
  logic          chg;
  logic          tick;
  logic [RW-1:0] run;
  logic [NEV-1:0] ev;

  pcw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (line_in),
    .level (line_s),
    .rise  (rise),
    .chg   (chg)
  );

  pcw_level_timer #(.CLK_DIV(CLK_DIV), .RUN_MAX(RUN_MAX)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (chg),
    .tick    (tick),
    .run     (run)
  );

  // An event fires once, on the tick that brings the level run to its limit
  for (genvar g = 0; g < NEV; g++) begin : g_ev
    assign ev[g] = tick && !chg && (line_s == EV_LVL[g]) && (run == RW'(EV_LIM[g] - 1));
  end

  always_ff @(posedge clk) begin
    if (rst)        dev_en <= 1'b0;
    else if (ev[4]) dev_en <= 1'b0;
    else if (ev[3]) dev_en <= 1'b1;
  end

  pcw_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .clear   (!dev_en),
    .rise    (rise),
    .hold_ev (ev[0]),
    .amax_ev (ev[1]),
    .stby_ev (ev[2]),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              line_s,
  input logic              dev_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  p_strobe_gated_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> dev_en);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_strobe_on_high_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> line_s);

  p_enable_on_high_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_en) |-> line_s);

  p_disable_on_low_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_en) |-> !line_s);

  p_addr_held_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_addr) |-> wr_en);

  p_data_held_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_data) |-> wr_en);
endmodule

bind pulse_count_writer pcw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .line_s  (line_s),
  .dev_en  (dev_en),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: tb/pulse_count_writer_test.sv
`timescale 1ns/1ps
module pulse_count_writer_test;
  localparam int D      = 2;
  localparam int HOLD   = 8;
  localparam int AMAX   = 40;
  localparam int EN     = 20;
  localparam int SD     = 60;
  localparam int STBY   = 90;
  localparam int LOWC   = 3;
  localparam int HIGHC  = 3;
  localparam int GAP    = 30;
  localparam int LAT    = 3 + HOLD * D;
  localparam int LAT_EN = 3 + EN * D;
  localparam int LAT_SD = 3 + SD * D;

  // {address pulses, data pulses, write expected, address, data}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{ 1,  1, 1,  0,  0},
    '{32, 64, 1, 31, 63},
    '{ 3,  4, 1,  2,  3},
    '{33,  0, 0,  0,  0},
    '{17, 42, 1, 16, 41},
    '{ 2, 65, 0,  0,  0},
    '{ 6,  1, 1,  5,  0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b0;
  logic       dev_en;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [5:0] wr_data;

  int checks = 0;
  int errors = 0;
  int nstrobe = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_count_writer #(
    .CLK_DIV(D), .HOLD_TICKS(HOLD), .ADDR_HOLD_MAX_TICKS(AMAX),
    .ENABLE_TICKS(EN), .SHUTDOWN_TICKS(SD), .STANDBY_TICKS(STBY),
    .ADDR_W(5), .DATA_W(6), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .line_in(line_in),
    .dev_en(dev_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (!rst && wr_en) nstrobe <= nstrobe + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_in = 1'b0;
      repeat (LOWC - 1) @(negedge clk);
      @(negedge clk) line_in = 1'b1;
      if (i != n - 1) repeat (HIGHC - 1) @(negedge clk);
    end
  endtask

  task automatic expect_write(input string req, input int a, input int d);
    int base;
    base = nstrobe;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk) check({req, " strobe early"}, wr_en, 0);
    @(posedge clk);
    @(negedge clk);
    check({req, " strobe"}, wr_en, 1);
    check({req, " addr"}, wr_addr, a);
    check({req, " data"}, wr_data, d);
    @(posedge clk);
    @(negedge clk) check({req, " strobe width"}, wr_en, 0);
    check({req, " strobe count"}, nstrobe - base, 1);
  endtask

  task automatic expect_none(input string req);
    int base;
    base = nstrobe;
    repeat (LAT + 4) @(posedge clk);
    @(negedge clk) check({req, " no strobe"}, nstrobe - base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    // R1 reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 dev_en", dev_en, 0);
    check("R1 wr_en", wr_en, 0);
    check("R1 wr_addr", wr_addr, 0);
    check("R1 wr_data", wr_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dev_en after release", dev_en, 0);
    check("R1 wr_en after release", wr_en, 0);

    // R9 transaction while disabled, then R2 enable timing
    base = nstrobe;
    pulses(3);
    repeat (GAP) @(negedge clk);
    pulses(4);
    repeat (LAT_EN - 1) @(posedge clk);
    @(negedge clk);
    check("R9 no strobe while disabled", nstrobe - base, 0);
    check("R2 enable not early", dev_en, 0);
    @(posedge clk);
    @(negedge clk) check("R2 enable on time", dev_en, 1);

    // R4 R5 R6 R7 vector table
    for (int v = 0; v < NV; v++) begin
      pulses(VEC[v][0]);
      if (VEC[v][1] == 0) begin
        expect_none("R6 address overflow");
      end else begin
        repeat (GAP) @(negedge clk);
        pulses(VEC[v][1]);
        if (VEC[v][2] != 0) expect_write("R4 R5 write", VEC[v][3], VEC[v][4]);
        else                expect_none("R7 data overflow");
      end
      repeat (10) @(negedge clk);
    end

    // R8 address hold too long
    base = nstrobe;
    pulses(3);
    repeat (2 + AMAX * D + 10) @(negedge clk);
    check("R8 abandoned address makes no write", nstrobe - base, 0);
    pulses(6);
    repeat (GAP) @(negedge clk);
    pulses(2);
    expect_write("R8 next train is address", 5, 1);
    repeat (10) @(negedge clk);

    // R3 shutdown mid-transaction, then re-enable
    pulses(5);
    repeat (GAP) @(negedge clk);
    @(negedge clk) line_in = 1'b0;
    repeat (LAT_SD - 1) @(posedge clk);
    @(negedge clk) check("R3 shutdown not early", dev_en, 1);
    @(posedge clk);
    @(negedge clk) check("R3 shutdown on time", dev_en, 0);
    line_in = 1'b1;
    repeat (LAT_EN) @(posedge clk);
    @(negedge clk) check("R2 re-enable", dev_en, 1);
    pulses(5);
    repeat (GAP) @(negedge clk);
    pulses(2);
    expect_write("R3 decoder cleared by shutdown", 4, 1);
    check("R3 enable held", dev_en, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule